// File: doc/BRIEF.md
# Banked SPI Register Command Decoder

This block is the serial slave front end of a controller whose registers are organised in four banks and which also owns a byte-wide buffer memory. A host drives an SPI link in mode 0 (data sampled on the rising SCK edge, shifted on the falling edge, most significant bit first). The block decodes each chip-select frame and turns it into accesses on a register-file port, on a buffer-memory port, or into a soft-reset pulse. The first byte of a frame is the command. Its top three bits select the operation and its low five bits give the register address.

Address 0x1F is a common register that answers in every bank. Its two low bits are the bank select. The block holds this register itself and shows it on `reg_bank`. Every other register address is qualified by that bank on the register port. For set and clear commands, the block reads the addressed register through the same port, applies the mask, and writes the result back. The buffer port carries a pointer that advances by one after each byte moved. Buffer transfers stream for as long as chip select stays low.

All SPI inputs are taken as already synchronous to `clk`. Each SCK half period must last at least two `clk` cycles.

Top module: `banked_spi_cmd`

## Requirements
- R1: The first complete byte after chip select falls is the command: bits 7:5 are the opcode and bits 4:0 the argument. 000 reads a register, 010 writes one, 100 sets bits, 101 clears bits, 0x3A reads the buffer, 0x7A writes the buffer and 0xFF is a soft reset. Any other byte (for example 0x25, 0xC3, 0xFE) is ignored for the rest of the frame: no strobe, no state change, and MISO stays 0.
- R2: After a write command, every complete data byte pulses `reg_we` for one cycle. During that pulse `reg_bank` shows the current bank, `reg_addr` the argument and `reg_wdata` the byte.
- R3: Set writes back (current value OR data byte), and clear writes back (current value AND NOT data byte). The current value is taken from `reg_rdata` for the bank and address shown.
- R4: Address 0x1F is held inside the block in every bank. A read returns 0b000000 followed by the two bank bits. Write, set and clear commands update the bank from data bits 1:0. None of these accesses ever pulses `reg_we` or `reg_re`.
- R5: A register read shifts out the value MSB first. The first bit is driven after the SCK falling edge that ends the command byte, and one bit follows each later falling edge. `reg_re` pulses once when the host starts clocking the real data byte.
- R6: A read in bank 2 at address 0x1A or below, or in bank 3 at address 0x05 or below or exactly 0x0A, first shifts out one 0x00 dummy byte and then the register value. Reads anywhere else have no dummy byte.
- R7: After a buffer-read command, each byte the host clocks comes from `buf_addr`, with one `buf_re` pulse. The pointer then advances by one, and this goes on until chip select rises.
- R8: After a buffer-write command, each complete data byte pulses `buf_we` once, with `buf_wdata` set to the byte and `buf_addr` at the current pointer. The pointer then advances by one.
- R9: Command 0xFF pulses `soft_rst` for one cycle and clears both the bank select and the buffer pointer to 0.
- R10: Raising chip select ends the command. A partly shifted byte is discarded without any strobe, and the next frame starts again with a command byte.
- R11: After reset, `reg_bank` and `buf_addr` are 0, MISO is 0 and all strobes are low.
- R12: At most one of `reg_we`, `reg_re`, `buf_we`, `buf_re` and `soft_rst` is high in any cycle, and none of them pulses unless chip select was low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not selected |
| reg_bank | output | 2 | Current bank select |
| reg_addr | output | 5 | Register address from the command |
| reg_wdata | output | 8 | Value to write into the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read-consumed strobe |
| reg_rdata | input | 8 | Combinational register-file read at reg_bank/reg_addr |
| buf_addr | output | BUF_AW | Buffer pointer |
| buf_wdata | output | 8 | Byte to write into the buffer |
| buf_we | output | 1 | One-cycle buffer write strobe |
| buf_re | output | 1 | One-cycle buffer read-consumed strobe |
| buf_rdata | input | 8 | Combinational buffer read at buf_addr |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
Some properties are checked by the assertions on every cycle. These are: strobes are mutually exclusive and appear only inside a frame; the common register never reaches the register-file write port; the pointer moves by exactly one after each buffer strobe; soft reset leaves bank and pointer at zero; and no read strobe fires while a dummy byte is still owed. Other behaviour can only be shown by the bench scenarios, which compare every strobe against a behavioural model. These are: the dummy-byte rule across banks and addresses, the read-modify-write values of set and clear, streaming order, discarding of partial bytes and silence on unknown commands.

// File: rtl/bsc_pkg.sv
// Shared constants, types and helpers for the banked SPI command decoder.
// Assumes an 8-bit command byte: opcode in bits 7:5, argument in bits 4:0.
package bsc_pkg;

    localparam int BYTE_W = 8;
    localparam int ARG_W  = 5;
    localparam int BANK_W = 2;

    localparam logic [2:0] OP_RD   = 3'b000;
    localparam logic [2:0] OP_RBUF = 3'b001;
    localparam logic [2:0] OP_WR   = 3'b010;
    localparam logic [2:0] OP_WBUF = 3'b011;
    localparam logic [2:0] OP_SET  = 3'b100;
    localparam logic [2:0] OP_CLR  = 3'b101;
    localparam logic [2:0] OP_RST  = 3'b111;

    localparam logic [ARG_W-1:0] ARG_BUF  = 5'h1A;
    localparam logic [ARG_W-1:0] ARG_BANK = 5'h1F;
    localparam logic [ARG_W-1:0] ARG_RST  = 5'h1F;

    localparam logic [ARG_W-1:0] DUMMY_B2_MAX  = 5'h1A;
    localparam logic [ARG_W-1:0] DUMMY_B3_MAX  = 5'h05;
    localparam logic [ARG_W-1:0] DUMMY_B3_ALSO = 5'h0A;

    typedef enum logic [2:0] {
        ST_CMD, ST_RREG, ST_WREG, ST_SET, ST_CLR, ST_RBUF, ST_WBUF, ST_SKIP
    } bsc_state_e;

    // True when a register read in this bank/address owes one dummy byte first.
    function automatic logic needs_dummy(input logic [BANK_W-1:0] bank,
                                         input logic [ARG_W-1:0]  a);
        return (bank == 2'd2 && a <= DUMMY_B2_MAX) ||
               (bank == 2'd3 && (a <= DUMMY_B3_MAX || a == DUMMY_B3_ALSO));
    endfunction

endpackage

// File: rtl/bsc_serdes.sv
// Mode-0 SPI shifter running in the system clock domain.
// Assumes sck/cs_n/mosi are synchronous to clk and each SCK half period
// lasts at least two clk cycles. It gives out a received byte with a strobe,
// a "next byte started" strobe, and loads tx_byte at each byte-boundary fall.
module bsc_serdes
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done,
    output logic              byte_start,
    output logic              miso
);
    localparam int              CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sck_q;
    logic              got_byte;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rise;
    logic              fall;

    // Edge detection and the byte-level strobes derived from it.
    always_comb begin
        rise       = sck & ~sck_q;
        fall       = ~sck & sck_q;
        rx_byte    = {rx_sr[BYTE_W-2:0], mosi};
        rx_done    = rise & ~cs_n & (bit_cnt == LAST_BIT);
        byte_start = rise & ~cs_n & got_byte & (bit_cnt == '0);
        miso       = tx_sr[BYTE_W-1] & ~cs_n;
    end

    // Shift registers and bit counter; everything clears while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            got_byte <= 1'b0;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
        end else begin
            sck_q <= sck;
            if (cs_n) begin
                got_byte <= 1'b0;
                bit_cnt  <= '0;
                tx_sr    <= '0;
            end else begin
                if (rise) begin
                    rx_sr   <= rx_byte;
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        got_byte <= 1'b1;
                    end
                end
                if (fall) begin
                    tx_sr <= (got_byte && bit_cnt == '0) ? tx_byte
                                                         : {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/bsc_ctrl.sv
// Command decoder and sequencer. It interprets the first byte of a frame,
// holds the common bank register, and drives register-port and buffer-port
// strobes. Assumes reg_rdata and buf_rdata are combinational reads of the
// addresses it presents.
module bsc_ctrl
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_done,
    input  logic              byte_start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BANK_W-1:0] reg_bank,
    output logic [ARG_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              buf_we,
    output logic              buf_re,
    output logic              soft_rst
);
    bsc_state_e        state;
    logic              dummy_left;
    logic [BANK_W-1:0] bank_q;
    logic [ARG_W-1:0]  addr_q;
    logic [ARG_W-1:0]  arg;
    logic [BYTE_W-1:0] rd_val;
    logic [BYTE_W-1:0] new_val;
    logic              is_bank;

    assign reg_bank = bank_q;
    assign reg_addr = addr_q;
    assign arg      = rx_byte[ARG_W-1:0];
    assign is_bank  = (addr_q == ARG_BANK);

    // Current value of the addressed register, common register included.
    always_comb rd_val = is_bank ? BYTE_W'(bank_q) : reg_rdata;

    // Value a write, set or clear produces from the received data byte.
    always_comb begin
        case (state)
            ST_SET:  new_val = rd_val | rx_byte;
            ST_CLR:  new_val = rd_val & ~rx_byte;
            default: new_val = rx_byte;
        endcase
    end

    // Byte offered to the shifter at the next byte boundary.
    always_comb begin
        case (state)
            ST_RREG: tx_byte = dummy_left ? '0 : rd_val;
            ST_RBUF: tx_byte = buf_rdata;
            default: tx_byte = '0;
        endcase
    end

    // Frame sequencing, bank register and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_CMD;
            dummy_left <= 1'b0;
            bank_q     <= '0;
            addr_q     <= '0;
            reg_wdata  <= '0;
            reg_we     <= 1'b0;
            reg_re     <= 1'b0;
            buf_wdata  <= '0;
            buf_we     <= 1'b0;
            buf_re     <= 1'b0;
            soft_rst   <= 1'b0;
        end else begin
            reg_we   <= 1'b0;
            reg_re   <= 1'b0;
            buf_we   <= 1'b0;
            buf_re   <= 1'b0;
            soft_rst <= 1'b0;
            if (cs_n) begin
                state      <= ST_CMD;
                dummy_left <= 1'b0;
            end else if (rx_done && state == ST_CMD) begin
                case (rx_byte[BYTE_W-1:ARG_W])
                    OP_RD: begin
                        state      <= ST_RREG;
                        addr_q     <= arg;
                        dummy_left <= needs_dummy(bank_q, arg);
                    end
                    OP_WR: begin
                        state  <= ST_WREG;
                        addr_q <= arg;
                    end
                    OP_SET: begin
                        state  <= ST_SET;
                        addr_q <= arg;
                    end
                    OP_CLR: begin
                        state  <= ST_CLR;
                        addr_q <= arg;
                    end
                    OP_RBUF: state <= (arg == ARG_BUF) ? ST_RBUF : ST_SKIP;
                    OP_WBUF: state <= (arg == ARG_BUF) ? ST_WBUF : ST_SKIP;
                    OP_RST: begin
                        state <= ST_SKIP;
                        if (arg == ARG_RST) begin
                            soft_rst <= 1'b1;
                            bank_q   <= '0;
                        end
                    end
                    default: state <= ST_SKIP;
                endcase
            end else if (rx_done) begin
                case (state)
                    ST_WREG, ST_SET, ST_CLR: begin
                        if (is_bank) begin
                            bank_q <= new_val[BANK_W-1:0];
                        end else begin
                            reg_we    <= 1'b1;
                            reg_wdata <= new_val;
                        end
                    end
                    ST_WBUF: begin
                        buf_we    <= 1'b1;
                        buf_wdata <= rx_byte;
                    end
                    default: ;
                endcase
            end else if (byte_start) begin
                case (state)
                    ST_RREG: begin
                        if (dummy_left) begin
                            dummy_left <= 1'b0;
                        end else if (!is_bank) begin
                            reg_re <= 1'b1;
                        end
                    end
                    ST_RBUF: buf_re <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // R12: strobes never overlap
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re, buf_we, buf_re, soft_rst}));

    // R12 / R10: strobes only follow a selected cycle
    p_strobe_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re || buf_we || buf_re || soft_rst) |-> $past(!cs_n));

    // R4: common register never reaches the register file
    p_bank_private_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || reg_re) |-> (reg_addr != ARG_BANK));

    // R9: soft reset leaves bank select at zero
    p_rst_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (reg_bank == '0));

    // R6: the real value is never consumed while a dummy byte is owed
    p_dummy_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> !dummy_left);

endmodule

// File: rtl/bsc_bufptr.sv
// Auto-incrementing buffer pointer. It advances on the cycle after each
// buffer strobe and clears on soft reset. Wraps at 2**AW.
module bsc_bufptr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    output logic [AW-1:0] ptr
);
    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R7 / R8: one step per consumed byte
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (ptr == $past(ptr) + 1'b1));

    // R9: soft reset clears the pointer
    p_ptr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == '0));

endmodule

// File: rtl/banked_spi_cmd.sv
// Top level of the banked SPI register command decoder. It ties the mode-0
// shifter, the command sequencer and the buffer pointer together. The
// register file and the buffer memory sit outside and answer combinationally.
module banked_spi_cmd
    import bsc_pkg::*;
#(
    parameter int BUF_AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [1:0]        reg_bank,
    output logic [4:0]        reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [7:0]        reg_rdata,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              buf_we,
    output logic              buf_re,
    input  logic [7:0]        buf_rdata,
    output logic              soft_rst
);
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic              rx_done;
    logic              byte_start;

    bsc_serdes u_serdes (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .tx_byte    (tx_byte),
        .rx_byte    (rx_byte),
        .rx_done    (rx_done),
        .byte_start (byte_start),
        .miso       (spi_miso)
    );

    bsc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .rx_byte    (rx_byte),
        .rx_done    (rx_done),
        .byte_start (byte_start),
        .tx_byte    (tx_byte),
        .reg_bank   (reg_bank),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_rdata  (reg_rdata),
        .buf_rdata  (buf_rdata),
        .buf_wdata  (buf_wdata),
        .buf_we     (buf_we),
        .buf_re     (buf_re),
        .soft_rst   (soft_rst)
    );

    bsc_bufptr #(.AW(BUF_AW)) u_bufptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (buf_we | buf_re),
        .clear (soft_rst),
        .ptr   (buf_addr)
    );

endmodule

// File: tb/banked_spi_cmd_bench.sv
`timescale 1ns/1ps
// Bench: acts as host, register file and buffer memory. A behavioural model
// predicts every strobe, and a monitor compares them on every clock.
module banked_spi_cmd_bench;
    localparam int AW = 13;
    localparam int H  = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sck, cs_n, mosi, miso;
    logic [1:0] reg_bank;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, buf_wdata, buf_rdata;
    logic reg_we, reg_re, buf_we, buf_re, soft_rst;
    logic [AW-1:0] buf_addr;

    logic [7:0] rf [4][32];
    logic [7:0] bmem [256];
    assign reg_rdata = rf[reg_bank][reg_addr];
    assign buf_rdata = bmem[buf_addr[7:0]];

    banked_spi_cmd #(.BUF_AW(AW)) u_banked_spi_cmd (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .reg_bank(reg_bank),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_we(buf_we), .buf_re(buf_re),
        .buf_rdata(buf_rdata), .soft_rst(soft_rst));

    // Model state
    int mrf [4][32];
    int mbm [256];
    int m_bank, m_ptr, n_rst_exp;
    int q_rw[$], q_rr[$], q_bw[$], q_br[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic unexp(input string what, input int act);
        n_chk++; n_bad++;
        $display("FAIL %s unexpected strobe act=%0h exp=none", what, act);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit dum(input int b, input int a);
        return (b == 2 && a <= 26) || (b == 3 && (a <= 5 || a == 10));
    endfunction

    // Monitor: every strobe must match the head of its expectation queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (q_rw.size() == 0) unexp("R2 reg_we", {reg_bank, reg_addr, reg_wdata});
                else chk("R2/R3 reg write {bank,addr,data}",
                         {reg_bank, reg_addr, reg_wdata}, q_rw.pop_front());
                rf[reg_bank][reg_addr] = reg_wdata;
            end
            if (reg_re) begin
                if (q_rr.size() == 0) unexp("R5 reg_re", {reg_bank, reg_addr});
                else chk("R5 reg_re {bank,addr}", {reg_bank, reg_addr}, q_rr.pop_front());
            end
            if (buf_we) begin
                if (q_bw.size() == 0) unexp("R8 buf_we", {buf_addr, buf_wdata});
                else chk("R8 buf write {addr,data}", {buf_addr, buf_wdata}, q_bw.pop_front());
                bmem[buf_addr[7:0]] = buf_wdata;
            end
            if (buf_re) begin
                if (q_br.size() == 0) unexp("R7 buf_re", int'(buf_addr));
                else chk("R7 buf_re addr", int'(buf_addr), q_br.pop_front());
            end
            if (soft_rst) begin
                if (n_rst_exp == 0) unexp("R9 soft_rst", 1);
                else begin n_rst_exp--; chk("R9 soft_rst pulse", 1, 1); end
            end
            if (cs_n && miso) chk("R11 miso idle", int'(miso), 0);
        end
    end

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic cs_low;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_high;
        repeat (H) @(negedge clk);
        cs_n = 1'b1; mosi = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 pending strobes at frame end",
            q_rw.size() + q_rr.size() + q_bw.size() + q_br.size() + n_rst_exp, 0);
    endtask

    // Write, set (op=1) or clear (op=2) on a register, one or more data bytes.
    task automatic do_wr(input int op, input int a, input int d0, input int nb);
        logic [7:0] r;
        logic [7:0] cmd;
        cmd = (op == 0) ? 8'h40 : (op == 1) ? 8'h80 : 8'hA0;
        cs_low;
        spi_byte(cmd | 8'(a), r);
        for (int k = 0; k < nb; k++) begin
            int d, cur, nv;
            d   = (d0 + k * 17) & 255;
            cur = (a == 31) ? m_bank : mrf[m_bank][a];
            nv  = (op == 0) ? d : (op == 1) ? (cur | d) : (cur & ~d & 255);
            if (a == 31) m_bank = nv & 3;
            else begin
                q_rw.push_back((m_bank << 13) | (a << 8) | nv);
                mrf[m_bank][a] = nv;
            end
            spi_byte(8'(d), r);
        end
        cs_high;
    endtask

    task automatic do_read(input int a, input string tag);
        logic [7:0] r;
        int ex;
        bit d;
        d  = dum(m_bank, a);
        ex = (a == 31) ? m_bank : mrf[m_bank][a];
        if (a != 31) q_rr.push_back((m_bank << 5) | a);
        cs_low;
        spi_byte(8'(a), r);
        if (d) begin
            spi_byte(8'h00, r);
            chk({tag, " R6 dummy byte"}, int'(r), 0);
        end
        spi_byte(8'h00, r);
        chk({tag, " read value"}, int'(r), ex);
        cs_high;
    endtask

    task automatic do_bufwr(input int n, input int seed);
        logic [7:0] r;
        cs_low;
        spi_byte(8'h7A, r);
        for (int k = 0; k < n; k++) begin
            int d;
            d = (seed + k * 37) & 255;
            q_bw.push_back(((m_ptr & ((1 << AW) - 1)) << 8) | d);
            mbm[m_ptr & 255] = d;
            m_ptr++;
            spi_byte(8'(d), r);
        end
        cs_high;
    endtask

    task automatic do_bufrd(input int n);
        logic [7:0] r;
        cs_low;
        spi_byte(8'h3A, r);
        for (int k = 0; k < n; k++) begin
            int ex;
            ex = mbm[m_ptr & 255];
            q_br.push_back(m_ptr & ((1 << AW) - 1));
            m_ptr++;
            spi_byte(8'h00, r);
            chk("R7 buffer stream byte", int'(r), ex);
        end
        cs_high;
    endtask

    task automatic do_ignored(input logic [7:0] cmd);
        logic [7:0] r;
        cs_low;
        spi_byte(cmd, r);
        spi_byte(8'hFF, r);
        chk("R1 ignored command miso", int'(r), 0);
        spi_byte(8'h55, r);
        chk("R1 ignored command miso", int'(r), 0);
        cs_high;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run;
    end

    initial begin
        logic [7:0] r;
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) begin
                rf[b][a]  = 8'((b * 32 + a) ^ 8'hC3);
                mrf[b][a] = (b * 32 + a) ^ 8'hC3;
            end
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'(i ^ 8'h5A);
            mbm[i]  = i ^ 8'h5A;
        end
        m_bank = 0; m_ptr = 0; n_rst_exp = 0;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reg_bank", int'(reg_bank), 0);
        chk("R11 buf_addr", int'(buf_addr), 0);
        chk("R11 miso", int'(miso), 0);
        chk("R11 strobes", int'({reg_we, reg_re, buf_we, buf_re, soft_rst}), 0);

        // R2 / R5 plain write and read in bank 0
        do_wr(0, 3, 8'hA5, 1);
        do_read(3, "R5 bank0 addr3");
        // R2 two data bytes in one frame
        do_wr(0, 7, 8'h11, 2);
        do_read(7, "R2 streamed write");

        // R4 common register: select bank 2 through a write
        do_wr(0, 31, 8'hFE, 1);
        chk("R4 reg_bank after write", int'(reg_bank), 2);
        do_read(31, "R4 bank register in bank 2");
        do_wr(0, 5, 8'h3C, 1);
        do_read(5, "R6 bank2 addr05");
        do_read(26, "R6 bank2 addr1A");
        do_read(27, "R6 bank2 addr1B");

        // R4 set on common register moves to bank 3
        do_wr(1, 31, 8'h01, 1);
        chk("R4 reg_bank after set", int'(reg_bank), 3);
        do_read(10, "R6 bank3 addr0A");
        do_read(6, "R6 bank3 addr06");
        do_read(5, "R6 bank3 addr05");

        // R3 set and clear as read-modify-write
        do_wr(1, 6, 8'h81, 1);
        do_wr(2, 6, 8'h0F, 1);
        do_read(6, "R3 after set/clear");

        // R4 clear on common register back to bank 1
        do_wr(2, 31, 8'h02, 1);
        chk("R4 reg_bank after clear", int'(reg_bank), 1);

        // R8 / R7 buffer streaming
        do_bufwr(5, 8'h21);
        chk("R8 pointer after writes", int'(buf_addr), 5);
        do_bufrd(3);
        chk("R7 pointer after reads", int'(buf_addr), 8);

        // R9 soft reset
        n_rst_exp++;
        cs_low; spi_byte(8'hFF, r); cs_high;
        m_bank = 0; m_ptr = 0;
        chk("R9 bank cleared", int'(reg_bank), 0);
        chk("R9 pointer cleared", int'(buf_addr), 0);
        do_bufrd(7);

        // R10 partial data byte is dropped
        cs_low; spi_byte(8'h43, r); spi_bits(8'hFF, 5, r); cs_high;
        do_read(3, "R10 after partial byte");

        // R1 unknown commands change nothing
        do_ignored(8'h25);
        do_ignored(8'hC3);
        do_ignored(8'hFE);
        chk("R1 bank after ignored", int'(reg_bank), 0);
        chk("R1 pointer after ignored", int'(buf_addr), 7);

        repeat (10) @(negedge clk);
        finish_run;
    end

endmodule